// File: doc/BRIEF.md
# Magnitude-Indexed Complex Gain Predistorter

This block linearizes a streaming complex baseband signal ahead of a power amplifier. Each accepted I/Q sample has its squared envelope (I² + Q²) computed, and the top bits of that value select a complex gain from an on-chip table. With interpolation enabled, the gain is blended between the selected entry and the one above it, using the envelope bits just below the address as the weight. The sample is then multiplied once by the complex gain. The product is rounded and saturated back to the sample width.

The table is held in two single-write, single-read memory banks, one for even addresses and one for odd addresses. The streaming path reads both neighbours in the same cycle. A separate write port lets an external agent replace entries while samples keep flowing, and the stream is never stalled. Each entry must be written before it is used, because the output for an unloaded entry is undefined. The input and output streams are both qualified by a valid bit, and the latency is fixed.

Top module: `gain_predistorter`

## Requirements
- R1: The table address is bits 30 down to 23 of the 32-bit unsigned squared envelope I² + Q². The interpolation weight is bits 22 down to 15. When bit 31 is set (envelope of 2^31), both the address and the weight saturate to 255.
- R2: A table write presents an 8-bit address, a signed 16-bit real gain and a signed 16-bit imaginary gain. The pair is stored as one word. Gains are Q2.14, so 16384 means 1.0.
- R3: The output real part is sat16((I·Gr − Q·Gi + 8192) >>> 14) and the output imaginary part is sat16((I·Gi + Q·Gr + 8192) >>> 14). The shift is arithmetic and sat16 clamps to the range −32768..32767.
- R4: With INTERP_EN = 1, each gain component is Ek + floor((Ek+1 − Ek)·w / 256), where w is the weight from R1.
- R5: With INTERP_EN = 0, the gain is entry k alone, and the weight has no effect on the output.
- R6: At address 255 the upper neighbour is entry 255 itself, never entry 0.
- R7: The output valid bit equals the input valid bit delayed by exactly 4 clock edges. Samples may arrive on consecutive cycles, and each produces its own result in order.
- R8: If a table write lands on the same edge as the stream's read of that entry, the read returns the value held before the write, with both halves from the old entry. Later samples see the new value.
- R9: While reset is low, the output valid bit and both output components are zero.
- R10: The output components hold their value in every cycle in which the output valid bit is low.
- R11: An input of I = Q = 0 produces an output of 0 + j0 for any loaded gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input sample qualifier |
| inI | input | DATA_W | Input in-phase sample, signed |
| inQ | input | DATA_W | Input quadrature sample, signed |
| tabWrEn | input | 1 | Table write strobe |
| tabWrAddr | input | ADDR_W | Table write address |
| tabWrRe | input | GAIN_W | Real gain to write, signed Q2.14 |
| tabWrIm | input | GAIN_W | Imaginary gain to write, signed Q2.14 |
| outValid | output | 1 | Output sample qualifier |
| outI | output | DATA_W | Predistorted in-phase output |
| outQ | output | DATA_W | Predistorted quadrature output |

## Verification
The bench builds two copies with the default widths (16-bit samples, Q2.14 gains, 256 entries, 8 weight bits): one with INTERP_EN = 1 and one with INTERP_EN = 0. Both copies receive the same stimulus, so every sample shows the blended gain and the plain entry side by side, and any effect of the weight in the non-interpolating copy stands out. Full-scale inputs reach address 255 and the saturated envelope, and the gain slope of the loaded table pushes those results into both saturation limits.

// File: rtl/gp_pkg.sv
package gp_pkg;

  // Fixed edge count from input capture to output register.
  localparam int GP_LATENCY = 4;

  // Per-stage load strobes issued by the control half.
  typedef struct packed {
    logic loadIn;
    logic readTab;
    logic mixGain;
    logic applyGain;
  } gpStrobes_t;

endpackage

// File: rtl/gp_ctrl.sv
module gp_ctrl
  import gp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output gpStrobes_t strb,
  output logic       outValid
);

  logic [GP_LATENCY-1:0] vldPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= {vldPipe[GP_LATENCY-2:0], inValid};
  end

  assign strb.loadIn    = inValid;
  assign strb.readTab   = vldPipe[0];
  assign strb.mixGain   = vldPipe[1];
  assign strb.applyGain = vldPipe[2];
  assign outValid       = vldPipe[GP_LATENCY-1];

endmodule

// File: rtl/gp_gain_bank.sv
module gp_gain_bank #(
  parameter int AW = 7,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Read-first: a read and write to one word on one edge returns the old word.
  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    if (rdEn) rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/gp_datapath.sv
module gp_datapath
  import gp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 14,
  parameter int ADDR_W    = 8,
  parameter int FRAC_W    = 8,
  parameter bit INTERP_EN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  gpStrobes_t               strb,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic signed [GAIN_W-1:0] wrGainRe,
  input  logic signed [GAIN_W-1:0] wrGainIm,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);

  localparam int ENV_W   = 2 * DATA_W;
  localparam int HEAD_W  = ADDR_W + FRAC_W + 1;
  localparam int SHIFT   = ENV_W - HEAD_W;
  localparam int BANK_AW = ADDR_W - 1;
  localparam int WORD_W  = 2 * GAIN_W;
  localparam int ACC_W   = DATA_W + GAIN_W + 1;
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
  localparam logic [ACC_W-1:0]  ROUND_HALF = ACC_W'(1) << (GAIN_FRAC - 1);
  localparam logic signed [ACC_W-1:0] LIM_HI = (ACC_W'(1) << (DATA_W - 1)) - 1;
  localparam logic signed [ACC_W-1:0] LIM_LO = -LIM_HI - 1;

  // ---------------- stage 1: envelope and address ----------------
  logic signed [ENV_W-1:0] sqI, sqQ;
  logic [ENV_W-1:0]        envSum;
  logic [HEAD_W-1:0]       envHead;
  logic [ADDR_W-1:0]       idxNow;
  logic [FRAC_W-1:0]       fracNow;

  assign sqI     = inI * inI;
  assign sqQ     = inQ * inQ;
  assign envSum  = $unsigned(sqI) + $unsigned(sqQ);
  assign envHead = HEAD_W'(envSum >> SHIFT);

  always_comb begin
    if (envHead[HEAD_W-1]) begin
      idxNow  = '1;
      fracNow = '1;
    end else begin
      idxNow  = envHead[HEAD_W-2 -: ADDR_W];
      fracNow = envHead[FRAC_W-1:0];
    end
  end

  logic signed [DATA_W-1:0] s1I, s1Q;
  logic [ADDR_W-1:0]        s1Idx;
  logic [FRAC_W-1:0]        s1Frac;

  always_ff @(posedge clk) begin
    if (strb.loadIn) begin
      s1I    <= inI;
      s1Q    <= inQ;
      s1Idx  <= idxNow;
      s1Frac <= fracNow;
    end
  end

  // ---------------- stage 2: banked table read ----------------
  logic [ADDR_W-1:0]  idxUp;
  logic [BANK_AW-1:0] bankRdAddr [2];
  logic [WORD_W-1:0]  bankWord   [2];

  assign idxUp         = (s1Idx == TOP_ADDR) ? s1Idx : s1Idx + 1'b1;
  assign bankRdAddr[0] = s1Idx[0] ? idxUp[ADDR_W-1:1] : s1Idx[ADDR_W-1:1];
  assign bankRdAddr[1] = s1Idx[ADDR_W-1:1];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    gp_gain_bank #(
      .AW(BANK_AW),
      .DW(WORD_W)
    ) u_bank (
      .clk   (clk),
      .rdEn  (strb.readTab),
      .rdAddr(bankRdAddr[b]),
      .rdData(bankWord[b]),
      .wrEn  (wrEn && (wrAddr[0] == 1'(b))),
      .wrAddr(wrAddr[ADDR_W-1:1]),
      .wrData({wrGainRe, wrGainIm})
    );
  end

  logic                     s2Odd, s2Top;
  logic [FRAC_W-1:0]        s2Frac;
  logic signed [DATA_W-1:0] s2I, s2Q;

  always_ff @(posedge clk) begin
    if (strb.readTab) begin
      s2Odd  <= s1Idx[0];
      s2Top  <= (s1Idx == TOP_ADDR);
      s2Frac <= s1Frac;
      s2I    <= s1I;
      s2Q    <= s1Q;
    end
  end

  // ---------------- stage 3: neighbour blend ----------------
  logic [WORD_W-1:0]        loWord, hiWord;
  logic signed [GAIN_W-1:0] gMix [2];

  assign loWord = s2Odd ? bankWord[1] : bankWord[0];
  assign hiWord = (s2Top || !s2Odd) ? bankWord[1] : bankWord[0];

  for (genvar c = 0; c < 2; c++) begin : g_comp
    logic signed [GAIN_W-1:0] gLo, gHi;
    assign gLo = loWord[(1-c)*GAIN_W +: GAIN_W];
    assign gHi = hiWord[(1-c)*GAIN_W +: GAIN_W];

    if (INTERP_EN) begin : g_interp
      logic signed [GAIN_W:0]          span, step, blend;
      logic signed [GAIN_W+FRAC_W+1:0] scaled;
      assign span     = gHi - gLo;
      assign scaled   = span * $signed({1'b0, s2Frac});
      assign step     = (GAIN_W+1)'(scaled >>> FRAC_W);
      assign blend    = gLo + step;
      assign gMix[c]  = blend[GAIN_W-1:0];
    end else begin : g_step
      assign gMix[c]  = gLo;
    end
  end

  logic signed [GAIN_W-1:0] s3GainRe, s3GainIm;
  logic signed [DATA_W-1:0] s3I, s3Q;

  always_ff @(posedge clk) begin
    if (strb.mixGain) begin
      s3GainRe <= gMix[0];
      s3GainIm <= gMix[1];
      s3I      <= s2I;
      s3Q      <= s2Q;
    end
  end

  // ---------------- stage 4: complex multiply, round, clip ----------------
  logic signed [ACC_W-1:0] accRe, accIm, rndRe, rndIm;

  assign accRe = s3I * s3GainRe - s3Q * s3GainIm;
  assign accIm = s3I * s3GainIm + s3Q * s3GainRe;
  assign rndRe = (accRe + $signed(ROUND_HALF)) >>> GAIN_FRAC;
  assign rndIm = (accIm + $signed(ROUND_HALF)) >>> GAIN_FRAC;

  function automatic logic signed [DATA_W-1:0] clip(input logic signed [ACC_W-1:0] v);
    if (v > LIM_HI)      return LIM_HI[DATA_W-1:0];
    else if (v < LIM_LO) return LIM_LO[DATA_W-1:0];
    else                 return v[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outI <= '0;
      outQ <= '0;
    end else if (strb.applyGain) begin
      outI <= clip(rndRe);
      outQ <= clip(rndIm);
    end
  end

endmodule

// File: rtl/gain_predistorter.sv
module gain_predistorter
  import gp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 14,
  parameter int ADDR_W    = 8,
  parameter int FRAC_W    = 8,
  parameter bit INTERP_EN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic                     tabWrEn,
  input  logic [ADDR_W-1:0]        tabWrAddr,
  input  logic signed [GAIN_W-1:0] tabWrRe,
  input  logic signed [GAIN_W-1:0] tabWrIm,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);

  gpStrobes_t strb;

  gp_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strb    (strb),
    .outValid(outValid)
  );

  gp_datapath #(
    .DATA_W   (DATA_W),
    .GAIN_W   (GAIN_W),
    .GAIN_FRAC(GAIN_FRAC),
    .ADDR_W   (ADDR_W),
    .FRAC_W   (FRAC_W),
    .INTERP_EN(INTERP_EN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inI     (inI),
    .inQ     (inQ),
    .wrEn    (tabWrEn),
    .wrAddr  (tabWrAddr),
    .wrGainRe(tabWrRe),
    .wrGainIm(tabWrIm),
    .outI    (outI),
    .outQ    (outQ)
  );

endmodule

// File: rtl/gp_checker.sv
module gp_checker #(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic signed [DATA_W-1:0] inI,
  input logic signed [DATA_W-1:0] inQ,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outI,
  input logic signed [DATA_W-1:0] outQ
);

  // Edges seen since reset was released, saturating.
  logic [2:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 3'd7) upCnt <= upCnt + 3'd1;
  end

  // R7
  latency_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 3'd4) |-> (outValid == $past(inValid, 4)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((upCnt >= 3'd1) && !outValid) |-> ($stable(outI) && $stable(outQ)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && outI == '0 && outQ == '0));

  // R11
  zero_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((upCnt >= 3'd4) && outValid && $past(inValid && inI == '0 && inQ == '0, 4))
      |-> (outI == '0 && outQ == '0));

endmodule

bind gain_predistorter gp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inI     (inI),
  .inQ     (inQ),
  .outValid(outValid),
  .outI    (outI),
  .outQ    (outQ)
);

// File: tb/gain_predistorter_test.sv
module gain_predistorter_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [15:0] inI = '0, inQ = '0;
  logic tabWrEn = 1'b0;
  logic [7:0] tabWrAddr = '0;
  logic signed [15:0] tabWrRe = '0, tabWrIm = '0;
  logic vA, vB;
  logic signed [15:0] aI, aQ, bI, bQ;

  always #5 clk = ~clk;

  gain_predistorter #(.INTERP_EN(1'b1)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .tabWrEn(tabWrEn), .tabWrAddr(tabWrAddr), .tabWrRe(tabWrRe), .tabWrIm(tabWrIm),
    .outValid(vA), .outI(aI), .outQ(aQ));

  gain_predistorter #(.INTERP_EN(1'b0)) uutStep (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .tabWrEn(tabWrEn), .tabWrAddr(tabWrAddr), .tabWrRe(tabWrRe), .tabWrIm(tabWrIm),
    .outValid(vB), .outI(bI), .outQ(bQ));

  int nChecks = 0;
  int nFail = 0;
  int shRe [256];
  int shIm [256];

  // {I, Q} stimulus; expected results come from the model below
  localparam int NVEC = 10;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'sd16384,  16'sd0},
    {-16'sd16384, 16'sd8000},
    {16'sd1000,   -16'sd2000},
    {16'sd30000,  16'sd0},
    {16'sd0,      16'sd0},
    {-16'sd20000, -16'sd20000},
    {16'sd32767,  16'sd32767},
    {-16'sd32768, -16'sd32768},
    {16'sd23170,  16'sd23170},
    {16'sd12345,  -16'sd30000}
  };

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // R1 address/weight, R4/R5 gain, R6 clamp, R3 multiply and rounding
  function automatic void model(input int i, input int q, input bit interp,
                                output int oI, output int oQ);
    longint env, k, f, kn, gr, gi, ar, ai;
    env = longint'(i) * i + longint'(q) * q;
    if (env >= 64'sd2147483648) begin k = 255; f = 255; end
    else begin k = env >> 23; f = (env >> 15) & 255; end
    kn = (k == 255) ? 255 : k + 1;
    gr = shRe[k];
    gi = shIm[k];
    if (interp) begin
      gr = gr + (((longint'(shRe[kn]) - shRe[k]) * f) >>> 8);
      gi = gi + (((longint'(shIm[kn]) - shIm[k]) * f) >>> 8);
    end
    ar = longint'(i) * gr - longint'(q) * gi;
    ai = longint'(i) * gi + longint'(q) * gr;
    oI = sat16((ar + 8192) >>> 14);
    oQ = sat16((ai + 8192) >>> 14);
  endfunction

  task automatic check(input string req, input int actI, input int actQ,
                       input int expI, input int expQ);
    nChecks++;
    if (actI != expI || actQ != expQ) begin
      nFail++;
      $display("FAIL %s: actual (%0d,%0d) expected (%0d,%0d)", req, actI, actQ, expI, expQ);
    end
  endtask

  task automatic writeEntry(input int a, input int re, input int im);
    @(negedge clk);
    tabWrEn = 1'b1; tabWrAddr = 8'(a); tabWrRe = 16'(re); tabWrIm = 16'(im);
    @(negedge clk);
    tabWrEn = 1'b0;
    shRe[a] = re;
    shIm[a] = im;
  endtask

  // One sample; checks valid timing (R7) and both instances' results.
  task automatic sendOne(input string req, input int i, input int q);
    int eI, eQ, sI, sQ;
    model(i, q, 1'b1, eI, eQ);
    model(i, q, 1'b0, sI, sQ);
    @(negedge clk);
    inValid = 1'b1; inI = 16'(i); inQ = 16'(q);
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R7 valid low before 4th edge", int'(vA), int'(vB), 0, 0);
    @(negedge clk);
    check("R7 valid after 4th edge", int'(vA), int'(vB), 1, 1);
    check({req, " R4 interp"}, int'(aI), int'(aQ), eI, eQ);
    check({req, " R5 no-interp"}, int'(bI), int'(bQ), sI, sQ);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nFail, nChecks);
    $finish;
  end

  initial begin : main
    int expI [6];
    int expQ [6];
    int oldI, oldQ, newI, newQ;

    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9 reset valid", int'(vA), int'(vB), 0, 0);
    check("R9 reset data", int'(aI), int'(aQ), 0, 0);
    check("R9 reset data step", int'(bI), int'(bQ), 0, 0);
    rstN = 1'b1;

    // R2 load all entries: re = 16384 + 64k, im = 8k - 1024
    for (int k = 0; k < 256; k++) writeEntry(k, 16384 + k * 64, k * 8 - 1024);

    // R1 R3 R4 R5 R6 R11 vector walk
    for (int n = 0; n < NVEC; n++)
      sendOne("R3 vector", int'($signed(VEC[n][31:16])), int'($signed(VEC[n][15:0])));

    // R10 outputs hold while idle
    oldI = int'(aI); oldQ = int'(aQ);
    repeat (3) @(negedge clk);
    check("R10 hold idle", int'(aI), int'(aQ), oldI, oldQ);

    // R7 back-to-back stream
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      if (n >= 4) check("R7 stream order", int'(aI), int'(aQ), expI[n-4], expQ[n-4]);
      if (n < 6) begin
        inValid = 1'b1;
        inI = 16'(n * 5000 - 12000);
        inQ = 16'(9000 - n * 3100);
        model(int'(inI), int'(inQ), 1'b1, expI[n], expQ[n]);
      end else begin
        inValid = 1'b0;
      end
    end

    // R8 write colliding with the stream read of entry 32
    model(16384, 0, 1'b1, oldI, oldQ);
    @(negedge clk);
    inValid = 1'b1; inI = 16'sd16384; inQ = 16'sd0;
    @(negedge clk);
    inValid = 1'b0;
    tabWrEn = 1'b1; tabWrAddr = 8'd32; tabWrRe = -16'sd8192; tabWrIm = 16'sd4096;
    @(negedge clk);
    tabWrEn = 1'b0;
    shRe[32] = -8192; shIm[32] = 4096;
    @(negedge clk);
    @(negedge clk);
    check("R8 old value on collision", int'(aI), int'(aQ), oldI, oldQ);
    model(16384, 0, 1'b1, newI, newQ);
    sendOne("R8 new value after write", 16384, 0);
    check("R8 new differs from old", int'(aI), int'(aQ), newI, newQ);

    // R6 top address clamps to itself
    writeEntry(255, 4096, 0);
    sendOne("R6 top clamp", 32767, 32767);
    check("R6 top clamp value", int'(aI), int'(aQ), 8192, 8192);

    // R11 zero input after gain change
    sendOne("R11 zero input", 0, 0);
    check("R11 zero output", int'(aI), int'(aQ), 0, 0);

    $display("Result: errors=%0d of %0d checks", nFail, nChecks);
    $finish;
  end

endmodule